// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This block is a small timer with one counter and two compare channels. The counter runs in one of four counting schemes: a plain wrapping up-count, an up-count that wraps at a programmable limit, a down-count that reloads from a programmable start value, and a triangle count that rises to a limit and falls back to zero. Each channel compares the counter against its own compare value. When they match, the channel sets, clears or toggles a registered output pin, as its 3-bit pin action code selects. It also emits a one-cycle event pulse that can trigger a DMA transfer. A separate one-cycle pulse marks the terminal count or the zero point of each counting period.

Software programs the block through a write-only register port. Channel 0's compare value also sets the period limit. A new value for it waits in a pending register and becomes active only when the counter is at zero. Channel 1's value is used as soon as it is written. In triangle mode, channel 0's event marks the zero turnaround rather than a compare match. The counter can be stopped and it can be cleared to zero.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, `count` is 0, both pins are 0, no event output is high, the counter is stopped in wrapping mode, and all compare values are 0.
- R2: Wrapping mode (mode code 0): while running, `count` goes up by one per cycle and wraps from the all-ones value to 0. `tcEvent` is high in the cycle after `count` showed all-ones.
- R3: Limit mode (mode code 1): `count` rises from 0 to the active channel 0 value and then returns to 0. `tcEvent` is high in the cycle after `count` showed that limit.
- R4: Down mode (mode code 2): `count` falls by one per cycle. In a cycle where it is 0, it reloads the pending channel 0 value on the next edge. `tcEvent` is high in the cycle after `count` showed 0.
- R5: Triangle mode (mode code 3): `count` rises from 0 to the active channel 0 value, then falls back to 0. In the cycle after each running cycle with `count` at 0, both `chEvent[0]` and `tcEvent` are high. If the active limit is 0, `count` stays at 0.
- R6: `chEvent[n]` is high for exactly the cycle after a running cycle in which `count` equals channel n's compare value. The exception is channel 0 in triangle mode, which follows R5.
- R7: In the cycle after a running match, each pin follows its 3-bit action code. The codes are: 0 sets the pin; 1 clears it; 2 toggles it; 3 sets it on a match and clears it when `count` is 0; 4 clears it on a match and sets it when `count` is 0; 5 to 7 leave it unchanged. A match takes priority over the zero action.
- R8: A write to channel 0's compare register goes to the pending value. The active value, used for matches and limits, copies the pending value on each edge at which `count` is 0.
- R9: A write to channel 1's compare register is used for matching from the next cycle onward.
- R10: While stopped, `count` and the pins hold their values and no event output goes high.
- R11: A control write with the clear bit set makes `count` 0 at that same edge, whether or not the counter is running, and overrides counting.
- R12: Register addresses: 0 is control (bits [1:0] mode, bit 2 run, bit 3 clear); 1 is channel 0 compare; 2 is channel 1 compare; 3 is channel 0 action code; 4 is channel 1 action code. The action codes sit in bits [2:0]. Run and mode take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | W | Register write data |
| count | output | W | Current counter value |
| pinOut | output | 2 | Registered channel output pins |
| chEvent | output | 2 | One-cycle per-channel event / DMA trigger pulses |
| tcEvent | output | 1 | One-cycle terminal-count / zero event |

## Verification
The bench builds the timer with W = 4. This makes a wrapping period only 16 cycles long. It also lets the sweep cover every compare value from 0 to 15 in all four counting modes, with all eight pin action codes on each channel. Each configuration is checked every cycle against a cycle-level model kept in the bench. Directed sequences exercise three cases: a channel 0 value changed in mid-period, which must not alter the current period; a channel 1 value changed in mid-period, which must hit in the same period; and stop and clear while the counter runs.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    CNT_FREE = 2'd0,
    CNT_MOD  = 2'd1,
    CNT_DOWN = 2'd2,
    CNT_UPDN = 2'd3
  } cntMode_e;

  localparam logic [2:0] PIN_SET      = 3'd0;
  localparam logic [2:0] PIN_CLR      = 3'd1;
  localparam logic [2:0] PIN_TGL      = 3'd2;
  localparam logic [2:0] PIN_SET_ZCLR = 3'd3;
  localparam logic [2:0] PIN_CLR_ZSET = 3'd4;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_CMP0 = 3'd1;
  localparam logic [2:0] ADR_CMP1 = 3'd2;
  localparam logic [2:0] ADR_PM0  = 3'd3;
  localparam logic [2:0] ADR_PM1  = 3'd4;

  localparam int CTL_RUN_BIT = 2;
  localparam int CTL_CLR_BIT = 3;

  typedef struct packed {
    logic     run;
    logic     clr;
    cntMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            wrAddr,
  input  logic [W-1:0]          wrData,
  output ctrlStrobe_t           strobe,
  output logic [W-1:0]          cmp0Pend,
  output logic [W-1:0]          cmp1Val,
  output logic [1:0][2:0]       pinMode
);

  logic     runQ;
  cntMode_e modeQ;
  logic     unusedData;

  assign unusedData = ^wrData;

  // R12 register decode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      modeQ    <= CNT_FREE;
      cmp0Pend <= '0;
      cmp1Val  <= '0;
      pinMode  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CTRL: begin
          runQ  <= wrData[CTL_RUN_BIT];
          modeQ <= cntMode_e'(wrData[1:0]);
        end
        ADR_CMP0: cmp0Pend   <= wrData;
        ADR_CMP1: cmp1Val    <= wrData;
        ADR_PM0:  pinMode[0] <= wrData[2:0];
        ADR_PM1:  pinMode[1] <= wrData[2:0];
        default: ;
      endcase
    end
  end

  // R11 clear acts at the write edge itself
  always_comb begin
    strobe.run  = runQ;
    strobe.mode = modeQ;
    strobe.clr  = wrEn && (wrAddr == ADR_CTRL) && wrData[CTL_CLR_BIT];
  end

endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [W-1:0]          cmp0Pend,
  input  logic [W-1:0]          cmp1Val,
  input  logic [1:0][2:0]       pinMode,
  output logic [W-1:0]          count,
  output logic [1:0]            pinOut,
  output logic [1:0]            chEvent,
  output logic                  tcEvent
);

  localparam int            NCH  = 2;
  localparam logic [W-1:0]  CMAX = {W{1'b1}};
  localparam logic [W-1:0]  ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]           cntQ, cntNext, cmp0Act;
  logic                   dirUpQ, dirNext, tcRaw, atZero;
  logic [NCH-1:0][W-1:0]  cmpVal;
  logic [NCH-1:0]         hit;
  logic                   pinQ [NCH];
  logic                   evQ  [NCH];

  assign atZero    = (cntQ == '0);
  assign cmpVal[0] = cmp0Act;
  assign cmpVal[1] = cmp1Val;

  // Counter next state per mode (R2..R5)
  always_comb begin
    cntNext = cntQ;
    dirNext = dirUpQ;
    tcRaw   = 1'b0;
    case (strobe.mode)
      CNT_FREE: begin
        cntNext = cntQ + ONE;
        tcRaw   = (cntQ == CMAX);
      end
      CNT_MOD: begin
        tcRaw   = (cntQ >= cmp0Act);
        cntNext = tcRaw ? '0 : cntQ + ONE;
      end
      CNT_DOWN: begin
        tcRaw   = atZero;
        cntNext = atZero ? cmp0Pend : cntQ - ONE;
      end
      CNT_UPDN: begin
        tcRaw = atZero;
        if (atZero)                dirNext = 1'b1;
        else if (cntQ >= cmp0Act)  dirNext = 1'b0;
        if (atZero && cmp0Act == '0) cntNext = cntQ;
        else                         cntNext = dirNext ? cntQ + ONE : cntQ - ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      dirUpQ  <= 1'b1;
      cmp0Act <= '0;
      tcQ     <= 1'b0;
    end else begin
      if (strobe.clr) begin
        cntQ   <= '0;
        dirUpQ <= 1'b1;
      end else if (strobe.run) begin
        cntQ   <= cntNext;
        dirUpQ <= dirNext;
      end
      if (atZero) cmp0Act <= cmp0Pend;   // R8 shadow transfer
      tcQ <= strobe.run && tcRaw;
    end
  end

  logic tcQ;

  // Per-channel compare, pin action and event (R6, R7)
  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    logic pinNext, evRaw;

    assign hit[ch] = (cntQ == cmpVal[ch]);

    if (ch == 0) begin : gEv0
      assign evRaw = (strobe.mode == CNT_UPDN) ? atZero : hit[ch];
    end else begin : gEvN
      assign evRaw = hit[ch];
    end

    always_comb begin
      pinNext = pinQ[ch];
      case (pinMode[ch])
        PIN_SET:      if (hit[ch]) pinNext = 1'b1;
        PIN_CLR:      if (hit[ch]) pinNext = 1'b0;
        PIN_TGL:      if (hit[ch]) pinNext = ~pinQ[ch];
        PIN_SET_ZCLR: if (hit[ch]) pinNext = 1'b1; else if (atZero) pinNext = 1'b0;
        PIN_CLR_ZSET: if (hit[ch]) pinNext = 1'b0; else if (atZero) pinNext = 1'b1;
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pinQ[ch] <= 1'b0;
        evQ[ch]  <= 1'b0;
      end else begin
        if (strobe.run) pinQ[ch] <= pinNext;
        evQ[ch] <= strobe.run && evRaw;
      end
    end

    assign pinOut[ch]  = pinQ[ch];
    assign chEvent[ch] = evQ[ch];
  end

  assign count   = cntQ;
  assign tcEvent = tcQ;

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrAddr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  count,
  output logic [1:0]    pinOut,
  output logic [1:0]    chEvent,
  output logic          tcEvent
);

  ctrlStrobe_t      strobe;
  logic [W-1:0]     cmp0Pend, cmp1Val;
  logic [1:0][2:0]  pinMode;
  logic             runNow, clrNow;
  logic [1:0]       modeNow;

  assign runNow  = strobe.run;
  assign clrNow  = strobe.clr;
  assign modeNow = strobe.mode;

  dct_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cmp0Pend(cmp0Pend), .cmp1Val(cmp1Val), .pinMode(pinMode)
  );

  dct_datapath #(.W(W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmp0Pend(cmp0Pend),
    .cmp1Val(cmp1Val), .pinMode(pinMode), .count(count), .pinOut(pinOut),
    .chEvent(chEvent), .tcEvent(tcEvent)
  );

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          runNow,
  input logic          clrNow,
  input logic [1:0]    modeNow,
  input logic [W-1:0]  cmp1Val,
  input logic [W-1:0]  count,
  input logic [1:0]    pinOut,
  input logic [1:0]    chEvent,
  input logic          tcEvent
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runNow && !clrNow) |=> ($stable(count) && $stable(pinOut))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |=> (chEvent == 2'b00 && !tcEvent)); // R10

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && !clrNow && modeNow == CNT_FREE) |=> (count == W'($past(count) + 1'b1))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && !clrNow && modeNow == CNT_DOWN && count != '0) |=> (count == W'($past(count) - 1'b1))); // R4

  AST_UPDN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && modeNow == CNT_UPDN) |=> (chEvent[0] == tcEvent)); // R5

  AST_CH1_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && count == cmp1Val) |=> chEvent[1]); // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clrNow |=> (count == '0)); // R11

endmodule

bind dual_cmp_timer dct_checker #(.W(W)) i_checker (
  .clk(clk), .rstN(rstN), .runNow(runNow), .clrNow(clrNow), .modeNow(modeNow),
  .cmp1Val(cmp1Val), .count(count), .pinOut(pinOut), .chEvent(chEvent),
  .tcEvent(tcEvent)
);

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic [1:0]   pinOut, chEvent;
  logic         tcEvent;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic monOn = 1'b0;
  string curReq = "R2";

  // bench model state
  logic [3:0] mCnt, mAct, mShadow, mCmp1;
  logic       mDir, mRun, mTc;
  logic [1:0] mMode;
  logic [2:0] mPm0, mPm1;
  logic       mPin0, mPin1, mEv0, mEv1;

  always #4 clk = ~clk;

  dual_cmp_timer #(.W(W)) i_dual_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .pinOut(pinOut), .chEvent(chEvent), .tcEvent(tcEvent)
  );

  function automatic logic pinStep(input logic [2:0] pm, input logic q,
                                   input logic h, input logic z);
    if (pm == 3'd0) return h ? 1'b1 : q;
    if (pm == 3'd1) return h ? 1'b0 : q;
    if (pm == 3'd2) return h ? ~q : q;
    if (pm == 3'd3) return h ? 1'b1 : (z ? 1'b0 : q);
    if (pm == 3'd4) return h ? 1'b0 : (z ? 1'b1 : q);
    return q;
  endfunction

  // cycle model built from R2..R12
  always @(posedge clk) begin
    logic z, h0, h1, nDir;
    logic [3:0] nCnt;
    if (!rstN) begin
      mCnt = 0; mAct = 0; mShadow = 0; mCmp1 = 0; mDir = 1; mRun = 0;
      mTc = 0; mMode = 0; mPm0 = 0; mPm1 = 0; mPin0 = 0; mPin1 = 0;
      mEv0 = 0; mEv1 = 0;
    end else begin
      z = (mCnt == 0); h0 = (mCnt == mAct); h1 = (mCnt == mCmp1);
      nCnt = mCnt; nDir = mDir;
      if (mRun) begin
        mEv0 = (mMode == 2'd3) ? z : h0;
        mEv1 = h1;
        mPin0 = pinStep(mPm0, mPin0, h0, z);
        mPin1 = pinStep(mPm1, mPin1, h1, z);
        if (mMode == 2'd0) begin
          mTc = (mCnt == 4'hF); nCnt = mCnt + 4'd1;
        end else if (mMode == 2'd1) begin
          mTc = (mCnt >= mAct); nCnt = mTc ? 4'd0 : mCnt + 4'd1;
        end else if (mMode == 2'd2) begin
          mTc = z; nCnt = z ? mShadow : mCnt - 4'd1;
        end else begin
          mTc = z;
          nDir = z ? 1'b1 : ((mCnt >= mAct) ? 1'b0 : mDir);
          nCnt = (z && mAct == 0) ? 4'd0 : (nDir ? mCnt + 4'd1 : mCnt - 4'd1);
        end
      end else begin
        mEv0 = 0; mEv1 = 0; mTc = 0;
      end
      if (wrEn && wrAddr == 3'd0 && wrData[3]) begin
        nCnt = 0; nDir = 1;
      end
      if (z) mAct = mShadow;
      mCnt = nCnt; mDir = nDir;
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mRun = wrData[2]; mMode = wrData[1:0]; end
          3'd1: mShadow = wrData;
          3'd2: mCmp1 = wrData;
          3'd3: mPm0 = wrData[2:0];
          3'd4: mPm1 = wrData[2:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      chk(curReq, int'(count), int'(mCnt));
      chk("R7", int'(pinOut), int'({mPin1, mPin0}));
      chk("R6", int'(chEvent), int'({mEv1, mEv0}));
      chk(curReq, int'(tcEvent), int'(mTc));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R12: writes are driven after a falling edge and taken at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [3:0] c0,
                       input logic [3:0] c1, input logic [2:0] p0,
                       input logic [2:0] p1);
    wr(3'd0, {2'b10, md});   // clear and stop (R11)
    wr(3'd1, c0);
    wr(3'd2, c1);
    wr(3'd3, {1'b0, p0});
    wr(3'd4, {1'b0, p1});
    wr(3'd0, {2'b01, md});   // run
  endtask

  initial begin
    int peak;
    int held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(count), 0);
    chk("R1", int'(pinOut), 0);
    chk("R1", int'(chEvent), 0);
    chk("R1", int'(tcEvent), 0);
    monOn = 1'b1;

    // Sweep: every mode, every channel 0 value, every pin code
    for (int md = 0; md < 4; md++) begin
      curReq = (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
      for (int c0 = 0; c0 < 16; c0++) begin
        for (int pm = 0; pm < 8; pm++) begin
          setup(2'(md), 4'(c0), 4'((c0 * 5 + 3) % 16), 3'(pm), 3'((pm + 3) % 8));
          repeat (36) @(negedge clk);
        end
      end
    end

    // R8: channel 0 change mid-period waits for zero
    curReq = "R8";
    setup(2'd1, 4'd5, 4'd15, 3'd7, 3'd7);
    while (count != 4'd2) @(negedge clk);
    wr(3'd1, 4'd9);
    peak = 0;
    do begin
      if (int'(count) > peak) peak = int'(count);
      @(negedge clk);
    end while (count != 0);
    chk("R8", peak, 5);
    peak = 0;
    do begin
      @(negedge clk);
      if (int'(count) > peak) peak = int'(count);
    end while (count != 0);
    chk("R8", peak, 9);

    // R9: channel 1 change mid-period hits in the same period
    curReq = "R9";
    setup(2'd1, 4'd12, 4'd10, 3'd7, 3'd7);
    while (count != 4'd3) @(negedge clk);
    wr(3'd2, 4'd6);
    while (count != 4'd6) @(negedge clk);
    @(negedge clk);
    chk("R9", int'(chEvent[1]), 1);

    // R10: stop holds count and silences events
    curReq = "R10";
    setup(2'd0, 4'd3, 4'd4, 3'd2, 3'd2);
    repeat (5) @(negedge clk);
    wr(3'd0, 4'b0000);
    held = int'(count);
    repeat (20) @(negedge clk);
    chk("R10", int'(count), held);
    chk("R10", int'(chEvent), 0);
    chk("R10", int'(tcEvent), 0);

    // R11: clear while running
    curReq = "R11";
    wr(3'd0, 4'b0100);
    repeat (7) @(negedge clk);
    wr(3'd0, 4'b1100);
    chk("R11", int'(count), 0);
    @(negedge clk);
    chk("R11", int'(count), 1);

    monOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule